// File: doc/BRIEF.md
# Clock-Generator SMBus Control Register Bank

This block is the configuration register bank of a programmable clock generator, reached over a two-wire SMBus slave port. Straps wired to the select and spread pins are captured once, on the first clock after reset. While the control-mode bit is clear, the frequency code and spread enable that leave the block follow the live pins. Once software sets the control-mode bit, they follow the register fields, and software may rewrite those fields.

A separate read-only byte always shows the live pin levels, whatever the control mode. Two fixed identification bytes are also readable. A writable count register sets how many register bytes a block read returns. The block also provides the per-output enable bits, the per-output stoppable mask, the stop drive mode and the spread type. The code index drives the synthesizer's frequency table. SCL and SDA are oversampled on the core clock, and the open-drain data line is pulled low through one output.

Top module: `clkgen_ctl_smbus`

## Requirements
- R1: After reset, `out_en_o` is 0xFF, `stop_mask_o` is 0x00, `stop_hiz_o` and `spread_center_o` are 0, and the byte-count register (index 6) reads 7. Index 4 always reads 0x01 and index 5 always reads 0x08.
- R2: On the first clock after reset, the control byte (index 0) captures the straps: bits 7:4 take `strap_fsel_i[3:0]` and bit 3 takes `strap_spread_i`. Bits 2:0 reset to 0. Later pin changes do not alter the captured bits.
- R3: While control bit 2 is 0 (hardware mode), `fsel_o` and `spread_en_o` follow the live strap pins, a few cycles after each pin change.
- R4: A write to index 0 always updates bits 2:0. It updates bits 7:3 only when the bit 2 stored before that write is 1.
- R5: While control bit 2 is 1 (software mode), `fsel_o` is control bits 7:4 and `spread_en_o` is control bit 3.
- R6: `freq_idx_o` equals the low three bits of the effective select code, so codes that differ only in bit 3 give the same index (0=100, 1=125, 2=133.33, 3=166.67, 4=200, 5=266.66, 6=333.33, 7=400 MHz).
- R7: Index 3 reads {live fsel[3:0], live spread, 3'b000}, in both control modes.
- R8: Writes that reach indices 3, 4 and 5 are acknowledged and have no effect.
- R9: A block write is: address 0xDC, command byte, count byte N, data bytes. The data bytes land at index 0 upward. Only the first N data bytes, and only those at indices below 7, are written. Index 1 drives `out_en_o`, index 2 drives `stop_mask_o`, and index 6 is the read count.
- R10: A block read to address 0xDD returns the count register value first, then indices 0, 1, ... up to that count, MSB first. Bytes past the count read 0xFF. A master NACK ends the transfer.
- R11: Only addresses 0xDC and 0xDD are acknowledged, and the slave then acknowledges every byte it receives in that transfer. After any other address, the slave neither acknowledges nor acts on any byte until the next START.
- R12: Control bit 1 drives `stop_hiz_o` (1 = high impedance when stopped) and bit 0 drives `spread_center_o` (1 = center spread).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SMBus clock line level |
| sda_i | input | 1 | SMBus data line level |
| sda_pull_o | output | 1 | 1 pulls the data line low |
| strap_fsel_i | input | 4 | Frequency select strap pins |
| strap_spread_i | input | 1 | Spread strap pin |
| fsel_o | output | 4 | Effective frequency select code |
| freq_idx_o | output | 3 | Frequency table index |
| spread_en_o | output | 1 | Effective spread enable |
| spread_center_o | output | 1 | Spread type, 1 = center |
| stop_hiz_o | output | 1 | Stop drive mode, 1 = high impedance |
| out_en_o | output | 8 | Per-output enables |
| stop_mask_o | output | 8 | Per-output stoppable flags |

## Verification
The assertions take for granted that the master changes SDA only while SCL is low, except to form START and STOP. They also assume each SCL level lasts many core clocks longer than the synchronizer delay, so that every edge is seen once and in order. The bench holds each SCL phase for ten core clocks. It changes its own data line two clocks after lowering SCL, and it moves the strap pins only between transfers, with SCL high and idle. Under those conditions, the write strobe reaches the register file only during acknowledge cycles.

// File: rtl/cg_pkg.sv
package cg_pkg;
  localparam int REG_COUNT = 7;
  localparam int IDX_W     = 3;
  localparam int BYTE_W    = 8;

  localparam logic [6:0] SLV_ADDR7 = 7'h6E;

  localparam logic [IDX_W-1:0] IDX_CTL   = 3'd0;
  localparam logic [IDX_W-1:0] IDX_OE    = 3'd1;
  localparam logic [IDX_W-1:0] IDX_STOPM = 3'd2;
  localparam logic [IDX_W-1:0] IDX_LIVE  = 3'd3;
  localparam logic [IDX_W-1:0] IDX_REVID = 3'd4;
  localparam logic [IDX_W-1:0] IDX_DEVID = 3'd5;
  localparam logic [IDX_W-1:0] IDX_BCNT  = 3'd6;

  localparam int CTL_SW  = 2;
  localparam int CTL_HIZ = 1;
  localparam int CTL_CTR = 0;
  localparam int CTL_SPR = 3;

  localparam logic [BYTE_W-1:0] OE_RST    = 8'hFF;
  localparam logic [BYTE_W-1:0] STOPM_RST = 8'h00;
  localparam logic [BYTE_W-1:0] BCNT_RST  = 8'd7;
  localparam logic [BYTE_W-1:0] REVID_VAL = 8'h01;
  localparam logic [BYTE_W-1:0] DEVID_VAL = 8'h08;

  typedef enum logic [2:0] {
    SMB_IDLE,
    SMB_RX,
    SMB_RX_ACK,
    SMB_TX,
    SMB_TX_ACK
  } smb_state_e;
endpackage

// File: rtl/cg_sync.sv
module cg_sync #(
  parameter int       W       = 1,
  parameter int       STAGES  = 2,
  parameter bit       USE_RST = 1'b1,
  parameter logic     RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;

  generate
    if (USE_RST) begin : g_rst
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= {STAGES{{W{RST_VAL}}}};
        else        pipe_q <= {pipe_q[STAGES-2:0], d_i};
      end
    end else begin : g_norst
      always_ff @(posedge clk) begin
        pipe_q <= {pipe_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/cg_smb_slave.sv
module cg_smb_slave
  import cg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl,
  input  logic              sda,
  input  logic [BYTE_W-1:0] bcnt,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic [BYTE_W-1:0] rd_idx,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sda_pull,
  output smb_state_e        state_o
);
  smb_state_e        state_q, state_d;
  logic [3:0]        bit_cnt_q, bit_cnt_d;
  logic [BYTE_W-1:0] byte_cnt_q, byte_cnt_d;
  logic [BYTE_W-1:0] shreg_q, shreg_d;
  logic [BYTE_W-1:0] wcount_q, wcount_d;
  logic [BYTE_W-1:0] tx_cnt_q, tx_cnt_d;
  logic              is_read_q, is_read_d;
  logic              mack_q, mack_d;
  logic              pull_q, pull_d;
  logic              scl_q, sda_q;

  logic              scl_rise, scl_fall, start_c, stop_c;
  logic [BYTE_W-1:0] data_idx, tx_byte, byte_cnt_inc, tx_cnt_inc;

  always_comb begin
    scl_rise = scl & ~scl_q;
    scl_fall = ~scl & scl_q;
    start_c  = scl & scl_q & sda_q & ~sda;
    stop_c   = scl & scl_q & ~sda_q & sda;
    data_idx = byte_cnt_q - 8'd3;
    byte_cnt_inc = (byte_cnt_q == 8'hFF) ? byte_cnt_q : byte_cnt_q + 8'd1;
    tx_cnt_inc   = (tx_cnt_q == 8'hFF) ? tx_cnt_q : tx_cnt_q + 8'd1;
    rd_idx   = (tx_cnt_q == 8'd0) ? 8'd0 : tx_cnt_q - 8'd1;
    if (tx_cnt_q == 8'd0)     tx_byte = bcnt;
    else if (tx_cnt_q <= bcnt) tx_byte = rd_byte;
    else                       tx_byte = 8'hFF;
  end

  always_comb begin
    state_d    = state_q;
    bit_cnt_d  = bit_cnt_q;
    byte_cnt_d = byte_cnt_q;
    shreg_d    = shreg_q;
    wcount_d   = wcount_q;
    tx_cnt_d   = tx_cnt_q;
    is_read_d  = is_read_q;
    mack_d     = mack_q;
    pull_d     = pull_q;
    wr_en      = 1'b0;
    wr_idx     = data_idx[IDX_W-1:0];
    wr_data    = shreg_q;

    if (start_c) begin
      state_d    = SMB_RX;
      bit_cnt_d  = 4'd0;
      byte_cnt_d = 8'd0;
      tx_cnt_d   = 8'd0;
      is_read_d  = 1'b0;
      pull_d     = 1'b0;
    end else if (stop_c) begin
      state_d = SMB_IDLE;
      pull_d  = 1'b0;
    end else begin
      unique case (state_q)
        SMB_IDLE: ;
        SMB_RX: begin
          if (scl_rise) begin
            shreg_d   = {shreg_q[6:0], sda};
            bit_cnt_d = bit_cnt_q + 4'd1;
          end else if (scl_fall && bit_cnt_q == 4'd8) begin
            byte_cnt_d = byte_cnt_inc;
            if (byte_cnt_q == 8'd0) begin
              if (shreg_q[7:1] == SLV_ADDR7) begin
                is_read_d = shreg_q[0];
                state_d   = SMB_RX_ACK;
                pull_d    = 1'b1;
              end else begin
                state_d = SMB_IDLE;
              end
            end else begin
              state_d = SMB_RX_ACK;
              pull_d  = 1'b1;
              if (byte_cnt_q == 8'd2) wcount_d = shreg_q;
              if (byte_cnt_q >= 8'd3 && data_idx < wcount_q &&
                  data_idx < REG_COUNT[BYTE_W-1:0]) begin
                wr_en = 1'b1;
              end
            end
          end
        end
        SMB_RX_ACK: begin
          if (scl_fall) begin
            bit_cnt_d = 4'd0;
            if (is_read_q) begin
              state_d  = SMB_TX;
              shreg_d  = tx_byte;
              pull_d   = ~tx_byte[7];
              tx_cnt_d = tx_cnt_inc;
            end else begin
              state_d = SMB_RX;
              pull_d  = 1'b0;
            end
          end
        end
        SMB_TX: begin
          if (scl_fall) begin
            if (bit_cnt_q == 4'd7) begin
              state_d = SMB_TX_ACK;
              pull_d  = 1'b0;
            end else begin
              shreg_d   = {shreg_q[6:0], 1'b0};
              pull_d    = ~shreg_q[6];
              bit_cnt_d = bit_cnt_q + 4'd1;
            end
          end
        end
        SMB_TX_ACK: begin
          if (scl_rise) begin
            mack_d = ~sda;
          end else if (scl_fall) begin
            if (mack_q) begin
              state_d   = SMB_TX;
              shreg_d   = tx_byte;
              pull_d    = ~tx_byte[7];
              tx_cnt_d  = tx_cnt_inc;
              bit_cnt_d = 4'd0;
            end else begin
              state_d = SMB_IDLE;
            end
          end
        end
        default: state_d = SMB_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SMB_IDLE;
      bit_cnt_q  <= 4'd0;
      byte_cnt_q <= 8'd0;
      shreg_q    <= 8'd0;
      wcount_q   <= 8'd0;
      tx_cnt_q   <= 8'd0;
      is_read_q  <= 1'b0;
      mack_q     <= 1'b0;
      pull_q     <= 1'b0;
      scl_q      <= 1'b1;
      sda_q      <= 1'b1;
    end else begin
      state_q    <= state_d;
      bit_cnt_q  <= bit_cnt_d;
      byte_cnt_q <= byte_cnt_d;
      shreg_q    <= shreg_d;
      wcount_q   <= wcount_d;
      tx_cnt_q   <= tx_cnt_d;
      is_read_q  <= is_read_d;
      mack_q     <= mack_d;
      pull_q     <= pull_d;
      scl_q      <= scl;
      sda_q      <= sda;
    end
  end

  assign sda_pull = pull_q;
  assign state_o  = state_q;
endmodule

// File: rtl/cg_reg_bank.sv
module cg_reg_bank
  import cg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        pin_fsel,
  input  logic              pin_spread,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [BYTE_W-1:0] rd_idx,
  output logic [BYTE_W-1:0] rd_byte,
  output logic [BYTE_W-1:0] ctl_q,
  output logic [BYTE_W-1:0] oe_q,
  output logic [BYTE_W-1:0] stopm_q,
  output logic [BYTE_W-1:0] bcnt_q
);
  logic              strap_done_q;
  logic              ctl_en, oe_en, stopm_en, bcnt_en;
  logic [BYTE_W-1:0] ctl_d;
  logic [BYTE_W-1:0] live_byte;

  assign live_byte = {pin_fsel, pin_spread, 3'b000};

  always_comb begin
    ctl_en   = 1'b0;
    oe_en    = 1'b0;
    stopm_en = 1'b0;
    bcnt_en  = 1'b0;
    ctl_d    = ctl_q;
    if (!strap_done_q) begin
      ctl_en     = 1'b1;
      ctl_d[7:3] = {pin_fsel, pin_spread};
    end else if (wr_en) begin
      unique case (wr_idx)
        IDX_CTL: begin
          ctl_en     = 1'b1;
          ctl_d[2:0] = wr_data[2:0];
          if (ctl_q[CTL_SW]) ctl_d[7:3] = wr_data[7:3];
        end
        IDX_OE:    oe_en    = 1'b1;
        IDX_STOPM: stopm_en = 1'b1;
        IDX_BCNT:  bcnt_en  = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_done_q <= 1'b0;
      ctl_q        <= 8'h00;
      oe_q         <= OE_RST;
      stopm_q      <= STOPM_RST;
      bcnt_q       <= BCNT_RST;
    end else begin
      strap_done_q <= 1'b1;
      if (ctl_en)   ctl_q   <= ctl_d;
      if (oe_en)    oe_q    <= wr_data;
      if (stopm_en) stopm_q <= wr_data;
      if (bcnt_en)  bcnt_q  <= wr_data;
    end
  end

  always_comb begin
    rd_byte = 8'h00;
    if (rd_idx[BYTE_W-1:IDX_W] == '0) begin
      unique case (rd_idx[IDX_W-1:0])
        IDX_CTL:   rd_byte = ctl_q;
        IDX_OE:    rd_byte = oe_q;
        IDX_STOPM: rd_byte = stopm_q;
        IDX_LIVE:  rd_byte = live_byte;
        IDX_REVID: rd_byte = REVID_VAL;
        IDX_DEVID: rd_byte = DEVID_VAL;
        IDX_BCNT:  rd_byte = bcnt_q;
        default:   rd_byte = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/clkgen_ctl_smbus.sv
module clkgen_ctl_smbus
  import cg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  input  logic [3:0] strap_fsel_i,
  input  logic       strap_spread_i,
  output logic [3:0] fsel_o,
  output logic [2:0] freq_idx_o,
  output logic       spread_en_o,
  output logic       spread_center_o,
  output logic       stop_hiz_o,
  output logic [7:0] out_en_o,
  output logic [7:0] stop_mask_o
);
  logic [1:0]        rst_pipe_q;
  logic              rst_sync_n;
  logic [1:0]        bus_s;
  logic [4:0]        pins_s;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [BYTE_W-1:0] wr_data, rd_idx, rd_byte, ctl_q, bcnt_q;
  smb_state_e        smb_state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  cg_sync #(.W(2), .STAGES(SYNC_STAGES), .USE_RST(1'b1), .RST_VAL(1'b1)) u_bus_sync (
    .clk(clk), .rst_n(rst_sync_n), .d_i({scl_i, sda_i}), .q_o(bus_s)
  );

  cg_sync #(.W(5), .STAGES(SYNC_STAGES), .USE_RST(1'b0), .RST_VAL(1'b0)) u_pin_sync (
    .clk(clk), .rst_n(rst_sync_n), .d_i({strap_fsel_i, strap_spread_i}), .q_o(pins_s)
  );

  cg_smb_slave u_slave (
    .clk(clk), .rst_n(rst_sync_n), .scl(bus_s[1]), .sda(bus_s[0]),
    .bcnt(bcnt_q), .rd_byte(rd_byte), .rd_idx(rd_idx),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .sda_pull(sda_pull_o), .state_o(smb_state)
  );

  cg_reg_bank u_bank (
    .clk(clk), .rst_n(rst_sync_n), .pin_fsel(pins_s[4:1]), .pin_spread(pins_s[0]),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_byte(rd_byte),
    .ctl_q(ctl_q), .oe_q(out_en_o), .stopm_q(stop_mask_o), .bcnt_q(bcnt_q)
  );

  always_comb begin
    fsel_o          = ctl_q[CTL_SW] ? ctl_q[7:4]     : pins_s[4:1];
    spread_en_o     = ctl_q[CTL_SW] ? ctl_q[CTL_SPR] : pins_s[0];
    freq_idx_o      = fsel_o[2:0];
    spread_center_o = ctl_q[CTL_CTR];
    stop_hiz_o      = ctl_q[CTL_HIZ];
  end
endmodule

// File: rtl/cg_ctl_checker.sv
module cg_ctl_checker
  import cg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              sda_pull,
  input smb_state_e        state,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_idx,
  input logic [BYTE_W-1:0] wr_data,
  input logic [BYTE_W-1:0] ctl_q,
  input logic [BYTE_W-1:0] bcnt_q,
  input logic [7:0]        out_en,
  input logic [7:0]        stop_mask
);
  AST_CTL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == IDX_CTL && !ctl_q[CTL_SW]) |=> (ctl_q[7:3] == $past(ctl_q[7:3]))); // R4

  AST_BCNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == IDX_BCNT) |=> (bcnt_q == $past(wr_data))); // R9

  AST_WR_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx < REG_COUNT[IDX_W-1:0])); // R9

  AST_OE_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_en) |-> $past(wr_en && wr_idx == IDX_OE)); // R12

  AST_STOPM_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stop_mask) |-> $past(wr_en && wr_idx == IDX_STOPM)); // R12

  AST_PULL_DRIVE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull |-> (state == SMB_RX_ACK || state == SMB_TX)); // R11
endmodule

bind clkgen_ctl_smbus cg_ctl_checker u_chk (
  .clk(clk), .rst_n(rst_sync_n), .sda_pull(sda_pull_o), .state(smb_state),
  .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .ctl_q(ctl_q),
  .bcnt_q(bcnt_q), .out_en(out_en_o), .stop_mask(stop_mask_o)
);

// File: tb/clkgen_ctl_smbus_tb.sv
module clkgen_ctl_smbus_tb;
  localparam int H = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [3:0] strap_fsel = 4'b1011;
  logic       strap_spread = 1'b1;
  logic       sda_pull;
  logic       sda_line;
  logic [3:0] fsel;
  logic [2:0] freq_idx;
  logic       spread_en, spread_center, stop_hiz;
  logic [7:0] out_en, stop_mask;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [7:0] rbuf [0:7];

  always #2.5 clk = ~clk;

  assign sda_line = sda_m & ~sda_pull;

  clkgen_ctl_smbus u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_pull_o(sda_pull),
    .strap_fsel_i(strap_fsel), .strap_spread_i(strap_spread),
    .fsel_o(fsel), .freq_idx_o(freq_idx), .spread_en_o(spread_en),
    .spread_center_o(spread_center), .stop_hiz_o(stop_hiz),
    .out_en_o(out_en), .stop_mask_o(stop_mask)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wclk(H);
    scl_m = 1'b1; wclk(H);
    sda_m = 1'b0; wclk(H);
    scl_m = 1'b0; wclk(2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wclk(H);
    scl_m = 1'b1; wclk(H);
    sda_m = 1'b1; wclk(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wclk(H);
      scl_m = 1'b1; wclk(H);
      scl_m = 1'b0; wclk(2);
    end
    sda_m = 1'b1; wclk(H);
    scl_m = 1'b1; wclk(H/2);
    acked = (sda_line == 1'b0);
    wclk(H/2);
    scl_m = 1'b0; wclk(2);
  endtask

  task automatic recv_byte(input bit last, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wclk(H);
      scl_m = 1'b1; wclk(H/2);
      b[i] = sda_line;
      wclk(H/2);
      scl_m = 1'b0; wclk(2);
    end
    sda_m = last; wclk(H);
    scl_m = 1'b1; wclk(H);
    scl_m = 1'b0; wclk(2);
    sda_m = 1'b1;
  endtask

  task automatic blk_write(input logic [7:0] cnt, input int n, input logic [7:0] d [0:7]);
    bit a, all_ok;
    all_ok = 1'b1;
    bus_start();
    send_byte(8'hDC, a); all_ok &= a;
    send_byte(8'h00, a); all_ok &= a;
    send_byte(cnt, a);   all_ok &= a;
    for (int k = 0; k < n; k++) begin
      send_byte(d[k], a); all_ok &= a;
    end
    bus_stop();
    chk("R11 write acks", {31'd0, all_ok}, 32'd1);
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    logic [7:0] d [0:7];
    foreach (d[k]) d[k] = 8'h00;
    d[0] = v;
    blk_write(8'd1, 1, d);
  endtask

  task automatic blk_read(input int n);
    bit a;
    bus_start();
    send_byte(8'hDD, a);
    chk("R11 read address ack", {31'd0, a}, 32'd1);
    for (int k = 0; k < n; k++) recv_byte(k == n - 1, rbuf[k]);
    bus_stop();
  endtask

  task automatic t_reset();
    chk("R1 out_en reset", {24'd0, out_en}, 32'hFF);
    chk("R1 stop_mask reset", {24'd0, stop_mask}, 32'h00);
    chk("R1 stop_hiz reset", {31'd0, stop_hiz}, 32'd0);
    chk("R1 spread_center reset", {31'd0, spread_center}, 32'd0);
    chk("R3 fsel follows pins", {28'd0, fsel}, 32'hB);
    chk("R3 spread follows pin", {31'd0, spread_en}, 32'd1);
    chk("R6 freq index", {29'd0, freq_idx}, 32'd3);
  endtask

  task automatic t_read_all();
    blk_read(8);
    chk("R10 count byte first", {24'd0, rbuf[0]}, 32'd7);
    chk("R2 strap capture", {24'd0, rbuf[1]}, 32'hB8);
    chk("R1 idx1", {24'd0, rbuf[2]}, 32'hFF);
    chk("R1 idx2", {24'd0, rbuf[3]}, 32'h00);
    chk("R7 live pins", {24'd0, rbuf[4]}, 32'hB8);
    chk("R1 rev id", {24'd0, rbuf[5]}, 32'h01);
    chk("R1 dev id", {24'd0, rbuf[6]}, 32'h08);
    chk("R1 count reg", {24'd0, rbuf[7]}, 32'h07);
  endtask

  task automatic t_hw_follow();
    strap_fsel = 4'b0110; strap_spread = 1'b0;
    wclk(10);
    chk("R3 fsel tracks pins", {28'd0, fsel}, 32'h6);
    chk("R3 spread tracks pin", {31'd0, spread_en}, 32'd0);
    chk("R6 freq index 6", {29'd0, freq_idx}, 32'd6);
    blk_read(5);
    chk("R2 captured bits held", {24'd0, rbuf[1]}, 32'hB8);
    chk("R7 live readback", {24'd0, rbuf[4]}, 32'h60);
  endtask

  task automatic t_locked_write();
    wr_ctl(8'hF3);
    blk_read(2);
    chk("R4 locked fields", {24'd0, rbuf[1]}, 32'hBB);
    chk("R12 stop_hiz", {31'd0, stop_hiz}, 32'd1);
    chk("R12 spread_center", {31'd0, spread_center}, 32'd1);
    chk("R3 still hardware", {28'd0, fsel}, 32'h6);
  endtask

  task automatic t_sw_mode();
    wr_ctl(8'h04);
    blk_read(2);
    chk("R4 enable write locked", {24'd0, rbuf[1]}, 32'hBC);
    chk("R5 fsel from reg", {28'd0, fsel}, 32'hB);
    chk("R5 spread from reg", {31'd0, spread_en}, 32'd1);
    chk("R6 top bit ignored", {29'd0, freq_idx}, 32'd3);
    wr_ctl(8'h74);
    chk("R5 fsel rewritten", {28'd0, fsel}, 32'h7);
    chk("R5 spread rewritten", {31'd0, spread_en}, 32'd0);
    chk("R6 freq index 7", {29'd0, freq_idx}, 32'd7);
    blk_read(5);
    chk("R7 live in sw mode", {24'd0, rbuf[4]}, 32'h60);
  endtask

  task automatic t_multi_write();
    logic [7:0] d [0:7];
    d = '{8'h74, 8'h5A, 8'hC3, 8'h11, 8'h22, 8'h33, 8'h03, 8'h00};
    blk_write(8'd7, 7, d);
    chk("R12 out_en", {24'd0, out_en}, 32'h5A);
    chk("R12 stop_mask", {24'd0, stop_mask}, 32'hC3);
    blk_read(5);
    chk("R10 short count", {24'd0, rbuf[0]}, 32'd3);
    chk("R10 idx0", {24'd0, rbuf[1]}, 32'h74);
    chk("R10 idx1", {24'd0, rbuf[2]}, 32'h5A);
    chk("R10 idx2", {24'd0, rbuf[3]}, 32'hC3);
    chk("R10 past count", {24'd0, rbuf[4]}, 32'hFF);
    d[6] = 8'h07;
    blk_write(8'd7, 7, d);
    blk_read(8);
    chk("R8 idx3 ignored", {24'd0, rbuf[4]}, 32'h60);
    chk("R8 idx4 ignored", {24'd0, rbuf[5]}, 32'h01);
    chk("R8 idx5 ignored", {24'd0, rbuf[6]}, 32'h08);
    chk("R9 count restored", {24'd0, rbuf[7]}, 32'h07);
  endtask

  task automatic t_count_limit();
    logic [7:0] d [0:7];
    d = '{8'h74, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    blk_write(8'd1, 2, d);
    chk("R9 beyond count not written", {24'd0, out_en}, 32'h5A);
  endtask

  task automatic t_bad_addr();
    bit a, any;
    any = 1'b0;
    bus_start();
    send_byte(8'hA0, a); any |= a;
    send_byte(8'h00, a); any |= a;
    send_byte(8'h01, a); any |= a;
    send_byte(8'h00, a); any |= a;
    bus_stop();
    chk("R11 foreign address nack", {31'd0, any}, 32'd0);
    bus_start();
    send_byte(8'hDE, a);
    bus_stop();
    chk("R11 near address nack", {31'd0, a}, 32'd0);
    chk("R11 no write", {24'd0, out_en}, 32'h5A);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    wclk(10);
    rst_n = 1'b1;
    wclk(10);
    t_reset();
    t_read_all();
    t_hw_follow();
    t_locked_write();
    t_sw_mode();
    t_multi_write();
    t_count_limit();
    t_bad_addr();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule